// File: doc/BRIEF.md
# Free-Running 64-bit Comparator Timer

This block is a 64-bit up-counter behind a 32-bit register window. A control word enables counting, sets an 8-bit clock divider, and turns on a 64-bit compare. When the compare is on and the count has reached or passed the compare value, a sticky event flag is set. The flag drives an interrupt line when interrupts are enabled, and software clears it by writing a one.

In auto-increment mode each match adds a 32-bit step to the compare value. The event therefore re-arms by itself at a fixed interval. Software reads the count as two words: reading the low word freezes a copy of the high word, so a following high-word read gives a coherent 64-bit value. Both count words and both compare words can be written, so software can preload them. Accesses are single-cycle and use aligned byte offsets.

Top module: `gtmr_top`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: Control (offset 0x8) bit 0 enables counting, and the count never advances by more than one per clock. Writing 0 to control freezes the count.
- R3: Control bits 15:8 hold a divider value p. While counting is enabled, the count advances once every p+1 clocks, so p=0 advances it on every clock.
- R4: A write to offset 0x0 or 0x4 replaces the low or high count word. In a cycle with such a write, the write takes effect and the count does not also advance.
- R5: When the low word wraps from 0xFFFFFFFF, the carry goes into the high word.
- R6: When control bit 1 is set and the unsigned 64-bit count is greater than or equal to the compare value, bit 0 of offset 0xC is set at the next edge. With bit 1 clear, the bit is never set.
- R7: Writing 1 to bit 0 of 0xC clears the flag, and writing 0 leaves it unchanged. If a match occurs in the same cycle as a clear, the flag stays set.
- R8: The compare value is at 0x10 (low) and 0x14 (high), and the step is at 0x18. With control bit 3 set, each match adds the zero-extended step to the compare value. A software write to a compare word in that same cycle takes priority over the addition.
- R9: `irq_o` is high exactly while the flag is set and control bit 2 is set.
- R10: A read of 0x4 returns the high count word as it stood at the most recent read of 0x0.
- R11: Control reads back bits 3:0 and 15:8, with all other bits 0. Offsets that are unaligned or at 0x1C and above read 0 and accept no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read of 0x0 captures the high word |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt: event flag AND interrupt enable |

## Verification
Two collisions matter here. The first is a match in the same cycle as a software clear of the flag. The bench provokes it by setting the compare value below a running count with auto-increment off, so a match is present on every cycle, and then writing the clear; the flag must read back as 1. The second is an auto-increment in the same cycle as a software write to the compare value. The bench provokes it by writing a compare word while the count is far ahead; the written value must read back unchanged on the next cycle. A behavioural model that advances one clock at a time judges both cases, along with every other cycle of the run.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int unsigned PSC_W = 8;

  typedef enum logic [2:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STAT   = 3'd3,
    REG_CMP_LO = 3'd4,
    REG_CMP_HI = 3'd5,
    REG_STEP   = 3'd6,
    REG_NONE   = 3'd7
  } reg_idx_t;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             auto_inc;
    logic             irq_en;
    logic             cmp_en;
    logic             cnt_en;
  } ctrl_t;
endpackage

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_cnt_q;

  // >= keeps the divider safe if div_i shrinks mid-count
  assign tick_o = en_i && (div_cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_cnt_q <= '0;
    else if (!en_i || tick_o)   div_cnt_q <= '0;
    else                        div_cnt_q <= div_cnt_q + 1'b1;
  end
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] cnt_o
);
  logic [2*DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_lo_i) cnt_q[DW-1:0] <= wdata_i;
    else if (wr_hi_i) cnt_q[2*DW-1:DW] <= wdata_i;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            cmp_en_i,
  input  logic            auto_i,
  input  logic            wr_lo_i,
  input  logic            wr_hi_i,
  input  logic            wr_step_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [2*DW-1:0] cmp_o,
  output logic [DW-1:0]   step_o,
  output logic            hit_o
);
  logic [2*DW-1:0] cmp_q;
  logic [DW-1:0]   step_q;

  assign hit_o = cmp_en_i && (cnt_i >= cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cmp_q <= '0;
    else if (wr_lo_i)            cmp_q[DW-1:0] <= wdata_i;
    else if (wr_hi_i)            cmp_q[2*DW-1:DW] <= wdata_i;
    else if (hit_o && auto_i)    cmp_q <= cmp_q + {{DW{1'b0}}, step_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        step_q <= '0;
    else if (wr_step_i) step_q <= wdata_i;
  end

  assign cmp_o  = cmp_q;
  assign step_o = step_q;
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  import gtmr_pkg::*;

  localparam int unsigned CW = 2 * DW;

  ctrl_t          ctrl_q;
  logic [DW-1:0]  hi_snap_q;
  logic           flag_q;
  logic [CW-1:0]  cnt_q, cmp_q;
  logic [DW-1:0]  step_q;
  logic           tick, hit;
  logic           in_map;
  reg_idx_t       idx;

  // aligned and inside the seven-word window
  assign in_map = (addr_i[1:0] == 2'b00) && ((addr_i >> 2) < ADDR_W'(REG_NONE));
  assign idx    = in_map ? reg_idx_t'(addr_i[4:2]) : REG_NONE;

  logic wr_cnt_lo, wr_cnt_hi, wr_ctrl, wr_stat, wr_cmp_lo, wr_cmp_hi, wr_step;
  logic wr_cnt, wr_cmp, clr_req, rd_lo;
  logic cnt_en, cmp_en, irq_en, auto_inc;

  assign wr_cnt_lo = wr_en_i && (idx == REG_CNT_LO);
  assign wr_cnt_hi = wr_en_i && (idx == REG_CNT_HI);
  assign wr_ctrl   = wr_en_i && (idx == REG_CTRL);
  assign wr_stat   = wr_en_i && (idx == REG_STAT);
  assign wr_cmp_lo = wr_en_i && (idx == REG_CMP_LO);
  assign wr_cmp_hi = wr_en_i && (idx == REG_CMP_HI);
  assign wr_step   = wr_en_i && (idx == REG_STEP);
  assign wr_cnt    = wr_cnt_lo || wr_cnt_hi;
  assign wr_cmp    = wr_cmp_lo || wr_cmp_hi;
  assign clr_req   = wr_stat && wdata_i[0];
  assign rd_lo     = rd_en_i && (idx == REG_CNT_LO);

  assign cnt_en   = ctrl_q.cnt_en;
  assign cmp_en   = ctrl_q.cmp_en;
  assign irq_en   = ctrl_q.irq_en;
  assign auto_inc = ctrl_q.auto_inc;

  gtmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en),
    .div_i  (ctrl_q.psc),
    .tick_o (tick)
  );

  gtmr_count #(.DW(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_q)
  );

  gtmr_compare #(.DW(DW)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_q),
    .cmp_en_i  (cmp_en),
    .auto_i    (auto_inc),
    .wr_lo_i   (wr_cmp_lo),
    .wr_hi_i   (wr_cmp_hi),
    .wr_step_i (wr_step),
    .wdata_i   (wdata_i),
    .cmp_o     (cmp_q),
    .step_o    (step_q),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.psc      <= wdata_i[8 +: PSC_W];
      ctrl_q.auto_inc <= wdata_i[3];
      ctrl_q.irq_en   <= wdata_i[2];
      ctrl_q.cmp_en   <= wdata_i[1];
      ctrl_q.cnt_en   <= wdata_i[0];
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (hit)     flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_snap_q <= '0;
    else if (rd_lo) hi_snap_q <= cnt_q[CW-1:DW];
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      REG_CNT_LO: rdata_o = cnt_q[DW-1:0];
      REG_CNT_HI: rdata_o = hi_snap_q;
      REG_CTRL:   rdata_o = {{(DW-16){1'b0}}, ctrl_q.psc, 4'b0000,
                             ctrl_q.auto_inc, ctrl_q.irq_en, ctrl_q.cmp_en, ctrl_q.cnt_en};
      REG_STAT:   rdata_o = {{(DW-1){1'b0}}, flag_q};
      REG_CMP_LO: rdata_o = cmp_q[DW-1:0];
      REG_CMP_HI: rdata_o = cmp_q[CW-1:DW];
      REG_STEP:   rdata_o = step_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && irq_en;
endmodule

// File: rtl/gtmr_chk.sv
module gtmr_chk #(
  parameter int unsigned DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2*DW-1:0] cnt_q,
  input logic [2*DW-1:0] cmp_q,
  input logic [DW-1:0]   step_q,
  input logic [DW-1:0]   hi_snap_q,
  input logic            flag_q,
  input logic            cnt_en,
  input logic            cmp_en,
  input logic            irq_en,
  input logic            auto_inc,
  input logic            wr_cnt,
  input logic            wr_cmp,
  input logic            clr_req,
  input logic            rd_lo,
  input logic            irq_o
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en && !wr_cnt |=> $stable(cnt_q));

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en && (cnt_q >= cmp_q) |=> flag_q);

  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_req |=> flag_q);

  // R8
  auto_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en && auto_inc && (cnt_q >= cmp_q) && !wr_cmp
    |=> cmp_q == $past(cmp_q) + {{DW{1'b0}}, $past(step_q)});

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_q && irq_en);

  // R10
  snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> hi_snap_q == $past(cnt_q[2*DW-1:DW]));
endmodule

bind gtmr_top gtmr_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_q     (cnt_q),
  .cmp_q     (cmp_q),
  .step_q    (step_q),
  .hi_snap_q (hi_snap_q),
  .flag_q    (flag_q),
  .cnt_en    (cnt_en),
  .cmp_en    (cmp_en),
  .irq_en    (irq_en),
  .auto_inc  (auto_inc),
  .wr_cnt    (wr_cnt),
  .wr_cmp    (wr_cmp),
  .clr_req   (clr_req),
  .rd_lo     (rd_lo),
  .irq_o     (irq_o)
);

// File: tb/gtmr_top_tb.sv
`timescale 1ns/1ps
module gtmr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  bit          run = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gtmr_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // reference state
  longint unsigned m_cnt = 0, m_cmp = 0;
  int unsigned     m_step = 0, m_snap = 0, m_pc = 0, m_psc = 0;
  bit              m_en = 0, m_cmp_en = 0, m_irq_en = 0, m_auto = 0, m_flag = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mapped(logic [4:0] a);
    return (a[1:0] == 2'b00) && (a < 5'd28);
  endfunction

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    if (!mapped(a)) return 32'h0;
    case (a[4:2])
      3'd0: return m_cnt[31:0];
      3'd1: return m_snap;
      3'd2: return {16'h0, m_psc[7:0], 4'h0, m_auto, m_irq_en, m_cmp_en, m_en};
      3'd3: return {31'h0, m_flag};
      3'd4: return m_cmp[31:0];
      3'd5: return m_cmp[63:32];
      default: return m_step;
    endcase
  endfunction

  function automatic string tag(logic [4:0] a);
    if (!mapped(a)) return "R11";
    case (a[4:2])
      3'd0: return "R2";
      3'd1: return "R10";
      3'd2: return "R11";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_snap = 0; m_pc = 0; m_psc = 0;
      m_en = 0; m_cmp_en = 0; m_irq_en = 0; m_auto = 0; m_flag = 0;
    end else begin
      bit hit, tick, wa;
      int unsigned wi;
      hit  = m_cmp_en && (m_cnt >= m_cmp);
      tick = m_en && (m_pc >= m_psc);
      wa   = wr_en && mapped(addr);
      wi   = int'(addr >> 2);
      if (rd_en && mapped(addr) && wi == 0) m_snap = m_cnt[63:32];
      m_pc = (!m_en || tick) ? 0 : m_pc + 1;
      if (wa && wi == 0)      m_cnt[31:0]  = wdata;
      else if (wa && wi == 1) m_cnt[63:32] = wdata;
      else if (tick)          m_cnt = m_cnt + 1;
      if (wa && wi == 4)      m_cmp[31:0]  = wdata;
      else if (wa && wi == 5) m_cmp[63:32] = wdata;
      else if (hit && m_auto) m_cmp = m_cmp + longint'(m_step);
      if (wa && wi == 6) m_step = wdata;
      if (hit) m_flag = 1;
      else if (wa && wi == 3 && wdata[0]) m_flag = 0;
      if (wa && wi == 2) begin
        m_psc = wdata[15:8]; m_auto = wdata[3]; m_irq_en = wdata[2];
        m_cmp_en = wdata[1]; m_en = wdata[0];
      end
    end
    #2;
    if (rst_n && run) begin
      chk(rdata == exp_rd(addr), tag(addr), rdata, exp_rd(addr));
      chk(irq == (m_flag && m_irq_en), "R9", irq, m_flag && m_irq_en);
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; rd_en = 0; addr = a; wdata = d;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); wr_en = 0; rd_en = 1; addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); wr_en = 0; rd_en = 0; addr = 5'h1C; end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, a0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run = 1;
    // R1 reset values
    for (int i = 0; i < 7; i++) begin
      rd(5'(i * 4), d);
      chk(d == 0, "R1", d, 0);
    end
    chk(irq == 0, "R1", irq, 0);

    // R11 readback and holes
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, d); chk(d == 32'h0000_FF0F, "R11", d, 32'h0000_FF0F);
    rd(5'h09, d); chk(d == 0, "R11", d, 0);
    wr(5'h1C, 32'h1234_5678);
    rd(5'h1C, d); chk(d == 0, "R11", d, 0);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);

    // R4 preload, R5 carry, R10 snapshot
    wr(5'h00, 32'hFFFF_FFF0);
    wr(5'h04, 32'h5);
    rd(5'h00, d); chk(d == 32'hFFFF_FFF0, "R4", d, 32'hFFFF_FFF0);
    rd(5'h04, d); chk(d == 5, "R4", d, 5);
    wr(5'h08, 32'h1);
    idle(30);
    rd(5'h00, d);
    rd(5'h04, d); chk(d == 6, "R5", d, 6);
    wr(5'h04, 32'h9);
    rd(5'h04, d); chk(d == 6, "R10", d, 6);
    rd(5'h00, d);
    rd(5'h04, d); chk(d == 9, "R10", d, 9);

    // R4 write beats increment
    wr(5'h00, 32'd100);
    rd(5'h00, d); chk(d == 100, "R4", d, 100);

    // R2 stop freezes
    wr(5'h08, 32'h0);
    rd(5'h00, a0); idle(20); rd(5'h00, b0);
    chk(a0 == b0, "R2", b0, a0);

    // R3 divider of 4
    wr(5'h08, 32'h0000_0301);
    idle(5);
    rd(5'h00, a0); idle(39); rd(5'h00, b0);
    chk(b0 - a0 == 10, "R3", b0 - a0, 10);

    // R6 compare match
    wr(5'h08, 32'h1);
    wr(5'h04, 32'h0); wr(5'h00, 32'h0);
    wr(5'h14, 32'h0); wr(5'h10, 32'd50); wr(5'h18, 32'h0);
    wr(5'h08, 32'h7);
    rd(5'h0C, d); chk(d == 0, "R6", d, 0);
    idle(60);
    rd(5'h0C, d); chk(d == 1, "R6", d, 1);
    chk(irq == 1, "R9", irq, 1);

    // R7 write 0 keeps, clear colliding with match keeps
    wr(5'h0C, 32'h0);
    rd(5'h0C, d); chk(d == 1, "R7", d, 1);
    wr(5'h0C, 32'h1);
    rd(5'h0C, d); chk(d == 1, "R7", d, 1);

    // R9 gated by enable
    wr(5'h08, 32'h3);
    rd(5'h0C, d); chk(irq == 0, "R9", irq, 0);

    // R6 compare off: clear sticks
    wr(5'h08, 32'h1);
    wr(5'h0C, 32'h1);
    idle(3);
    rd(5'h0C, d); chk(d == 0, "R6", d, 0);

    // R8 auto-increment
    wr(5'h04, 32'h0); wr(5'h00, 32'h0);
    wr(5'h10, 32'd20); wr(5'h18, 32'd25);
    wr(5'h08, 32'hF);
    idle(100);
    rd(5'h10, d);
    chk((d >= 120) && ((d - 20) % 25 == 0), "R8", d, 120);

    // R8 write beats increment while far behind
    wr(5'h18, 32'h1);
    wr(5'h00, 32'd100000);
    wr(5'h10, 32'd7);
    rd(5'h10, d); chk(d == 7, "R8", d, 7);
    idle(10);
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'h1);
    idle(5);

    run = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule